// File: doc/BRIEF.md
# Status and LED Output Driver

This block sets the levels of four general-purpose output pins (A, B, C and D) on a voice-playback controller. It takes a busy flag from the playback engine, a sample-rate tick and an option code for each pin. From these it produces a pin level that reports playback status or drives an indicator LED. An LED can flash fast or slow, run a proportional duty pattern, or stay static. Each pin has its own set of options. Every option has a fixed level that the pin holds while nothing is playing.

A three-state machine follows the busy flag, and a set of tick counters runs beside it. The states are `ST_IDLE` (nothing playing), `ST_PLAY` (a sentence is playing) and `ST_STOP` (the single cycle after playback ends). The transitions are:

- `ST_IDLE→ST_PLAY` when busy is sampled high.
- `ST_PLAY→ST_STOP` when busy is sampled low.
- `ST_STOP→ST_PLAY` when busy is sampled high again.
- `ST_STOP→ST_IDLE` otherwise.

The tick counters count only in `ST_PLAY` and are cleared in every other state. Each pin decodes its own option code against these shared timing signals. LED options assume an LED sinking into the pin, so a low pin means lit.

Top module: `status_led_driver`

## Requirements
- R1: While reset is asserted, and just after it, every pin holds the idle level of its current option.
- R2: Busy-high drives the pin high exactly while the state is `ST_PLAY`. The state is the busy flag delayed by one clock. Busy-low (pin C status code 2; pin D code 1) is the inverse. Status codes are `opt[2]=0` with the index in `opt[1:0]`. Pin D uses a 1-bit code: 0 is busy-high and 1 is busy-low.
- R3: Drive-low (status index 1, pins A/B/C) holds the pin low at all times. Drive-high (status index 3) holds it high at all times.
- R4: Stop-high (status index 2, pins A and B only) is high for exactly one clock, in `ST_STOP`, and low at all other times.
- R5: Fast flash (LED code `opt[2]=1`, index 0) uses phase = floor(n/FAST_HALF) mod 2, where n is the number of ticks counted since playback started. The pin equals the phase on pins A and C, and the inverted phase on pin B.
- R6: Slow flash (LED index 1) follows the same rule as R5 with SLOW_HALF. Pin B is again inverted.
- R7: Dynamic mode (LED index 2) divides playback into slots of DYN_BASE ticks, with slot = floor(n/DYN_BASE) mod 10. The pin is low (lit) in slots 0–6 on pin A and slots 0–8 on pin B, and high otherwise.
- R8: LED-on (pin B index 3, pin C index 2) is low while playing and high otherwise. LED-off (pins A and C index 3) is always high.
- R9: When not playing, every LED option holds the pin high. The status options hold their idle levels: low for busy-high, drive-low and stop-high; high for busy-low and drive-high.
- R10: One clock after busy is sampled low, each pin is at its idle level. A new play counts ticks from zero, even when it starts straight from `ST_STOP`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | High while the playback engine is playing a sentence |
| tick | input | 1 | One-cycle sample-rate tick |
| opt_a | input | 3 | Pin A option: bit 2 selects LED, bits 1:0 the index |
| opt_b | input | 3 | Pin B option, same layout as pin A |
| opt_c | input | 3 | Pin C option, same layout as pin A |
| opt_d | input | 1 | Pin D option: 0 busy-high, 1 busy-low |
| pin_a | output | 1 | Pin A level |
| pin_b | output | 1 | Pin B level |
| pin_c | output | 1 | Pin C level |
| pin_d | output | 1 | Pin D level |

## Verification
The end of playback can land on the same edge as a tick that would otherwise advance a flash phase or a dynamic slot. At that edge the counter step and the return to idle compete. The bench ends every playback with busy low and tick high on the same edge. The next cycle is then judged to show the idle level (or the stop strobe), with no late flash edge. A one-cycle low gap between two plays also puts the stop strobe and a fresh counter start on neighbouring edges, and the bench checks that the new play starts at phase zero.

// File: rtl/sled_pkg.sv
package sled_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PLAY,
        ST_STOP
    } sled_state_e;

    typedef enum logic [1:0] {
        KIND_A,
        KIND_B,
        KIND_C,
        KIND_D
    } pin_kind_e;

    typedef enum logic [3:0] {
        MD_BUSY_HI,
        MD_BUSY_LO,
        MD_DRV_LO,
        MD_DRV_HI,
        MD_STOP_HI,
        MD_FAST_P,
        MD_FAST_N,
        MD_SLOW_P,
        MD_SLOW_N,
        MD_DYN_A,
        MD_DYN_B,
        MD_LED_ON,
        MD_LED_OFF
    } pin_mode_e;

    typedef struct packed {
        logic playing;
        logic stop_strobe;
        logic fast_ph;
        logic slow_ph;
        logic dyn_a_lit;
        logic dyn_b_lit;
    } timebase_t;

    // Per-pin option tables; bit 2 picks the LED group, bits 1:0 the entry.
    function automatic pin_mode_e decode_mode(pin_kind_e kind, logic [2:0] code);
        pin_mode_e m;
        m = MD_DRV_LO;
        if (kind == KIND_D) begin
            m = code[0] ? MD_BUSY_LO : MD_BUSY_HI;
        end else if (!code[2]) begin
            unique case (code[1:0])
                2'd0: m = MD_BUSY_HI;
                2'd1: m = MD_DRV_LO;
                2'd2: m = (kind == KIND_C) ? MD_BUSY_LO : MD_STOP_HI;
                2'd3: m = MD_DRV_HI;
                default: m = MD_DRV_LO;
            endcase
        end else begin
            unique case (code[1:0])
                2'd0: m = (kind == KIND_B) ? MD_FAST_N : MD_FAST_P;
                2'd1: m = (kind == KIND_B) ? MD_SLOW_N : MD_SLOW_P;
                2'd2: begin
                    if (kind == KIND_A)      m = MD_DYN_A;
                    else if (kind == KIND_B) m = MD_DYN_B;
                    else                     m = MD_LED_ON;
                end
                2'd3: m = (kind == KIND_B) ? MD_LED_ON : MD_LED_OFF;
                default: m = MD_LED_OFF;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/sled_timebase.sv
module sled_timebase
    import sled_pkg::*;
#(
    parameter int FAST_HALF = 2048,
    parameter int SLOW_HALF = 8192,
    parameter int DYN_BASE  = 64,
    parameter int DYN_SLOTS = 10,
    parameter int DYN_LIT_A = 7,
    parameter int DYN_LIT_B = 9
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      busy,
    input  logic      tick,
    output timebase_t tb
);

    localparam int FB = $clog2(FAST_HALF);
    localparam int SB = $clog2(SLOW_HALF);
    localparam int CW = SB + 1;
    localparam int BW = $clog2(DYN_BASE);
    localparam int SW = $clog2(DYN_SLOTS);

    sled_state_e     state, state_nx;
    logic [CW-1:0]   ph_cnt;
    logic [BW-1:0]   base_cnt;
    logic [SW-1:0]   slot;
    logic            in_play;

    initial begin
        AST_FAST_POW2: assert ((1 << FB) == FAST_HALF && FAST_HALF < SLOW_HALF); // R5
        AST_SLOW_POW2: assert ((1 << SB) == SLOW_HALF);                          // R6
        AST_DYN_SHAPE: assert (DYN_BASE >= 2 && DYN_LIT_A <= DYN_SLOTS && DYN_LIT_B <= DYN_SLOTS); // R7
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = busy ? ST_PLAY : ST_IDLE;
            ST_PLAY: state_nx = busy ? ST_PLAY : ST_STOP;
            ST_STOP: state_nx = busy ? ST_PLAY : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    assign in_play = (state == ST_PLAY);

    // tick counters, live only during playback
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt   <= '0;
            base_cnt <= '0;
            slot     <= '0;
        end else if (!in_play) begin
            ph_cnt   <= '0;
            base_cnt <= '0;
            slot     <= '0;
        end else if (tick) begin
            ph_cnt <= ph_cnt + 1'b1;
            if (base_cnt == BW'(DYN_BASE - 1)) begin
                base_cnt <= '0;
                slot     <= (slot == SW'(DYN_SLOTS - 1)) ? '0 : slot + 1'b1;
            end else begin
                base_cnt <= base_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tb             = '0;
        tb.fast_ph     = ph_cnt[FB];
        tb.slow_ph     = ph_cnt[SB];
        tb.dyn_a_lit   = (slot < SW'(DYN_LIT_A));
        tb.dyn_b_lit   = (slot < SW'(DYN_LIT_B));
        unique case (state)
            ST_IDLE: begin
                tb.playing     = 1'b0;
                tb.stop_strobe = 1'b0;
            end
            ST_PLAY: begin
                tb.playing     = 1'b1;
                tb.stop_strobe = 1'b0;
            end
            ST_STOP: begin
                tb.playing     = 1'b0;
                tb.stop_strobe = 1'b1;
            end
            default: begin
                tb.playing     = 1'b0;
                tb.stop_strobe = 1'b0;
            end
        endcase
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot < SW'(DYN_SLOTS)); // R7
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STOP |=> state != ST_STOP); // R4
    AST_CNT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_play) |-> (ph_cnt == '0 && base_cnt == '0 && slot == '0)); // R10
    AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_play && busy && !tick) |=> $stable(ph_cnt)); // R5

endmodule

// File: rtl/sled_pin.sv
module sled_pin
    import sled_pkg::*;
#(
    parameter pin_kind_e KIND = KIND_A
) (
    input  logic [2:0] code,
    input  timebase_t  tb,
    output logic       level
);

    pin_mode_e mode;

    always_comb begin
        mode  = decode_mode(KIND, code);
        level = 1'b1;
        unique case (mode)
            MD_BUSY_HI: level = tb.playing;
            MD_BUSY_LO: level = !tb.playing;
            MD_DRV_LO:  level = 1'b0;
            MD_DRV_HI:  level = 1'b1;
            MD_STOP_HI: level = tb.stop_strobe;
            MD_FAST_P:  level = tb.playing ? tb.fast_ph   : 1'b1;
            MD_FAST_N:  level = tb.playing ? !tb.fast_ph  : 1'b1;
            MD_SLOW_P:  level = tb.playing ? tb.slow_ph   : 1'b1;
            MD_SLOW_N:  level = tb.playing ? !tb.slow_ph  : 1'b1;
            MD_DYN_A:   level = tb.playing ? !tb.dyn_a_lit : 1'b1;
            MD_DYN_B:   level = tb.playing ? !tb.dyn_b_lit : 1'b1;
            MD_LED_ON:  level = !tb.playing;
            MD_LED_OFF: level = 1'b1;
            default:    level = 1'b1;
        endcase
    end

endmodule

// File: rtl/status_led_driver.sv
module status_led_driver
    import sled_pkg::*;
#(
    parameter int FAST_HALF = 2048,
    parameter int SLOW_HALF = 8192,
    parameter int DYN_BASE  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       tick,
    input  logic [2:0] opt_a,
    input  logic [2:0] opt_b,
    input  logic [2:0] opt_c,
    input  logic       opt_d,
    output logic       pin_a,
    output logic       pin_b,
    output logic       pin_c,
    output logic       pin_d
);

    localparam int NPINS = 4;

    timebase_t             tb;
    logic [NPINS-1:0][2:0] codes;
    logic [NPINS-1:0]      levels;

    sled_timebase #(
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF),
        .DYN_BASE  (DYN_BASE),
        .DYN_SLOTS (10),
        .DYN_LIT_A (7),
        .DYN_LIT_B (9)
    ) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .tick  (tick),
        .tb    (tb)
    );

    assign codes[0] = opt_a;
    assign codes[1] = opt_b;
    assign codes[2] = opt_c;
    assign codes[3] = {2'b00, opt_d};

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        localparam pin_kind_e K = pin_kind_e'(g);
        sled_pin #(.KIND(K)) u_pin (
            .code  (codes[g]),
            .tb    (tb),
            .level (levels[g])
        );
    end

    assign pin_a = levels[0];
    assign pin_b = levels[1];
    assign pin_c = levels[2];
    assign pin_d = levels[3];

    AST_PIN_D_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (pin_d == opt_d)); // R10
    AST_LED_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (!opt_a[2] || pin_a)); // R9
    AST_DRV_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_c == 3'b001) |-> !pin_c); // R3

endmodule

// File: tb/tb_status_led_driver.sv
`timescale 1ns/1ps
module tb_status_led_driver;

    localparam int FH = 4;
    localparam int SH = 16;
    localparam int DB = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    logic       busy, tick;
    logic [2:0] opt_a, opt_b, opt_c;
    logic       opt_d;
    logic       pin_a, pin_b, pin_c, pin_d;

    status_led_driver #(.FAST_HALF(FH), .SLOW_HALF(SH), .DYN_BASE(DB)) dut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .tick(tick),
        .opt_a(opt_a), .opt_b(opt_b), .opt_c(opt_c), .opt_d(opt_d),
        .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .pin_d(pin_d)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference timing: play = busy one clock late, stop = first idle cycle
    logic m_play, m_stop;
    int   n;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_play <= 1'b0;
            m_stop <= 1'b0;
            n      <= 0;
        end else begin
            m_play <= busy;
            m_stop <= m_play && !busy;
            if (!m_play)   n <= 0;
            else if (tick) n <= n + 1;
        end
    end

    function automatic logic exp_level(input int kind, input logic [2:0] code,
                                       input logic play, input logic stop,
                                       input int cnt, output string tag);
        logic lv;
        logic fast, slow;
        int   slot;
        bit   strobe_mode;
        fast = ((cnt / FH) % 2) == 1;
        slow = ((cnt / SH) % 2) == 1;
        slot = (cnt / DB) % 10;
        strobe_mode = 0;
        lv = 1'b1;
        tag = "R2";
        if (kind == 3) begin
            lv = code[0] ? !play : play; tag = "R2";
        end else if (!code[2]) begin
            case (code[1:0])
                2'd0: begin lv = play; tag = "R2"; end
                2'd1: begin lv = 1'b0; tag = "R3"; end
                2'd2: begin
                    if (kind == 2) begin lv = !play; tag = "R2"; end
                    else begin lv = stop; tag = "R4"; strobe_mode = 1; end
                end
                default: begin lv = 1'b1; tag = "R3"; end
            endcase
        end else begin
            case (code[1:0])
                2'd0: begin lv = play ? ((kind == 1) ? !fast : fast) : 1'b1; tag = "R5"; end
                2'd1: begin lv = play ? ((kind == 1) ? !slow : slow) : 1'b1; tag = "R6"; end
                2'd2: begin
                    if (kind == 0)      begin lv = play ? !(slot < 7) : 1'b1; tag = "R7"; end
                    else if (kind == 1) begin lv = play ? !(slot < 9) : 1'b1; tag = "R7"; end
                    else                begin lv = !play; tag = "R8"; end
                end
                default: begin lv = (kind == 1) ? !play : 1'b1; tag = "R8"; end
            endcase
        end
        if (!play) begin
            if (stop && !strobe_mode) tag = "R10";
            else if (!stop && !strobe_mode) tag = "R9";
        end
        return lv;
    endfunction

    task automatic chk(input string tag, input string name, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, expv, $time);
        end
    endtask

    task automatic check_all(input bit at_reset);
        string t;
        logic  e;
        e = exp_level(0, opt_a, m_play, m_stop, n, t);
        chk(at_reset ? "R1" : t, "pin_a", pin_a, e);
        e = exp_level(1, opt_b, m_play, m_stop, n, t);
        chk(at_reset ? "R1" : t, "pin_b", pin_b, e);
        e = exp_level(2, opt_c, m_play, m_stop, n, t);
        chk(at_reset ? "R1" : t, "pin_c", pin_c, e);
        e = exp_level(3, {2'b00, opt_d}, m_play, m_stop, n, t);
        chk(at_reset ? "R1" : t, "pin_d", pin_d, e);
    endtask

    task automatic step(input logic b, input logic t);
        @(negedge clk);
        check_all(0);
        busy = b;
        tick = t;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not finish");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        busy  = 1'b0;
        tick  = 1'b0;
        opt_a = 3'd0; opt_b = 3'd0; opt_c = 3'd0; opt_d = 1'b0;

        // R1: idle level under reset for every option code
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            opt_a = 3'(i); opt_b = 3'(i); opt_c = 3'(i); opt_d = i[0];
            @(negedge clk);
            check_all(1);
        end
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            opt_a = 3'(i); opt_b = 3'(i); opt_c = 3'(i); opt_d = i[0] ^ i[2];
            for (int k = 0; k < 3; k++) step(0, 0);
            // long play: covers flash periods and several dynamic cycles
            for (int k = 0; k < 90; k++) begin
                step(1, (k % 3) != 2);
                if (k == 45) opt_c = 3'((i + 3) % 8);
            end
            // R10: busy falls on the same edge as a tick
            step(0, 1);
            for (int k = 0; k < 3; k++) step(0, 0);
            // R4 / R10: single-cycle gap restarts counting from zero
            step(1, 1);
            step(0, 1);
            for (int k = 0; k < 12; k++) step(1, 1);
            step(0, 1);
            for (int k = 0; k < 3; k++) step(0, 0);
        end
        step(0, 0);
        finish_run();
    end

endmodule